// File: doc/BRIEF.md
# Exposure Setting Capture Register

This block holds the exposure setting used by the electronic-shutter sequencer of a CCD camera timing generator. It reads the setting from one of two sources. A format-select pin picks the source. One source is a 3-bit code held on static pins, which the block turns into a fixed load value and shutter mode. The other is a three-wire serial link with strobe, clock and data lines. Over that link a host shifts in a 12-bit frame that holds a 9-bit load value and a 2-bit mode.

The serial lines are asynchronous to the system clock, so the block synchronizes them first. It shifts data on each rising edge of the serial clock. The shifted frame is committed to an active register only when the strobe falls after exactly one full frame. A short frame or an over-long frame leaves the previous setting in place. The selected setting then passes through a shutter-enable gate and a guard against the illegal load value. The result is registered and presented as load value, mode and shutter-on flag.

Top module: `shutcfg_top`

## Requirements
- R1: With `fmt_par` high the outputs follow the parallel code; with `fmt_par` low they follow the serial active register. The outputs settle within 2 clock cycles of a change on any static input.
- R2: The serial data line is sampled on each rising edge of the serial clock. Frame bit 0 is load bit 0, and frame bits 0 to 8 give load bits 0 to 8. Frame bit 9 drives `shut_mode[1]` and frame bit 10 drives `shut_mode[0]`. Frame bit 11 is a dummy and is ignored. Mode code 00 is flickerless, 01 is fast shutter, 10 is slow shutter and 11 is no shutter.
- R3: A falling strobe commits the frame only if exactly 12 serial clock rises came since the previous strobe fall or since reset. After 11 or 13 rises the active register keeps its old value.
- R4: In 525-line parallel operation (`std_625` low) the codes map as follows. Code 7 gives no shutter with load 0. Code 6 gives flickerless with load 0x196. Codes 5 down to 0 give fast shutter with loads 0x137, 0x118, 0x108, 0x100, 0x0FC and 0x0FA.
- R5: In 625-line parallel operation (`std_625` high) code 7 gives no shutter with load 0. Code 6 gives flickerless with load 0x149. Codes 5 down to 0 give fast shutter with loads 0x105, 0x0E6, 0x0D6, 0x0CE, 0x0CA and 0x0C8.
- R6: While `shut_en` is low the outputs are `shut_on`=0, mode 11 and load 0, whatever either source holds.
- R7: A serial load value of 0x1FF acts as no shutter: `shut_on`=0, mode 11, load 0.
- R8: `shut_on` is 1 exactly when `shut_en` is high, the selected mode is not 11 and the load is not 0x1FF. In that case load and mode are passed through unchanged.
- R9: After reset the serial active register holds no shutter with load 0, and the outputs read `shut_on`=0, mode 11, load 0.
- R10: Serial frames are received and committed even while the parallel source is selected. A later switch to serial shows the committed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_par | input | 1 | Source select: 1 parallel code, 0 serial link |
| std_625 | input | 1 | Line standard for the parallel table: 0 525-line, 1 625-line |
| par_code | input | 3 | Parallel exposure code |
| ser_stb | input | 1 | Serial strobe; a falling edge commits a frame |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data |
| shut_en | input | 1 | Shutter enable; low forces the shutter off |
| load_val | output | 9 | Decoded load value |
| shut_mode | output | 2 | Decoded shutter mode |
| shut_on | output | 1 | Electronic shutter active |

## Verification
Two functions can fall in the same clock cycle: a serial commit and a change of the source-select or enable gating. The bench drives the strobe's falling edge on the same clock as a flip of `fmt_par`. It also sends a full frame while the parallel source is shown. It then judges that the output first tracks the parallel table and, after the switch, shows exactly the new frame. A commit made while `shut_en` is low must likewise appear only once the enable returns.

// File: rtl/shutcfg_pkg.sv
package shutcfg_pkg;

  localparam int LOAD_W  = 9;
  localparam int MODE_W  = 2;
  localparam int CODE_W  = 3;
  localparam int PAD_W   = 1;
  localparam int FRAME_W = LOAD_W + MODE_W + PAD_W;

  typedef enum logic [MODE_W-1:0] {
    MODE_FLICKERLESS = 2'b00,
    MODE_FAST        = 2'b01,
    MODE_SLOW        = 2'b10,
    MODE_NONE        = 2'b11
  } shut_mode_e;

  typedef struct packed {
    logic [LOAD_W-1:0] load;
    shut_mode_e        mode;
  } shut_setting_t;

  localparam shut_setting_t SETTING_OFF = '{load: '0, mode: MODE_NONE};

endpackage

// File: rtl/shutcfg_sync.sv
module shutcfg_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= RST_VAL;
          else        stg_q[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= RST_VAL;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/shutcfg_par_dec.sv
module shutcfg_par_dec
  import shutcfg_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              std_625,
  output shut_setting_t     setting
);

  logic [LOAD_W-1:0] load_525;
  logic [LOAD_W-1:0] load_625;
  logic [LOAD_W-1:0] load_sel;

  always_comb begin
    unique case (code)
      3'd0:    begin load_525 = 9'h0FA; load_625 = 9'h0C8; end
      3'd1:    begin load_525 = 9'h0FC; load_625 = 9'h0CA; end
      3'd2:    begin load_525 = 9'h100; load_625 = 9'h0CE; end
      3'd3:    begin load_525 = 9'h108; load_625 = 9'h0D6; end
      3'd4:    begin load_525 = 9'h118; load_625 = 9'h0E6; end
      3'd5:    begin load_525 = 9'h137; load_625 = 9'h105; end
      3'd6:    begin load_525 = 9'h196; load_625 = 9'h149; end
      default: begin load_525 = '0;     load_625 = '0;     end
    endcase
  end

  assign load_sel = std_625 ? load_625 : load_525;

  always_comb begin
    setting.load = load_sel;
    if (code == 3'd7)      setting.mode = MODE_NONE;
    else if (code == 3'd6) setting.mode = MODE_FLICKERLESS;
    else                   setting.mode = MODE_FAST;
  end

endmodule

// File: rtl/shutcfg_ser_rx.sv
module shutcfg_ser_rx
  import shutcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_stb,
  input  logic          ser_clk,
  input  logic          ser_dat,
  output shut_setting_t active
);

  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic [2:0] pins_s;
  logic       clk_s, dat_s, stb_s;
  logic       clk_prev_q, stb_prev_q;
  logic       clk_rise, stb_fall;

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  shut_setting_t      act_q, act_d;
  logic               sr_en, cnt_en, act_en;

  shutcfg_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({ser_stb, ser_dat, ser_clk}),
    .dout  (pins_s)
  );

  assign clk_s = pins_s[0];
  assign dat_s = pins_s[1];
  assign stb_s = pins_s[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev_q <= 1'b0;
      stb_prev_q <= 1'b1;
    end else begin
      clk_prev_q <= clk_s;
      stb_prev_q <= stb_s;
    end
  end

  assign clk_rise = clk_s & ~clk_prev_q;
  assign stb_fall = ~stb_s & stb_prev_q;

  always_comb begin
    sr_d   = {dat_s, sr_q[FRAME_W-1:1]};
    sr_en  = clk_rise;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    act_d  = act_q;
    act_en = 1'b0;
    if (clk_rise && cnt_q != CNT_SAT) begin
      cnt_d  = cnt_q + CNT_W'(1);
      cnt_en = 1'b1;
    end
    if (stb_fall) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
      if (cnt_q == CNT_FULL) begin
        act_d.load = sr_q[LOAD_W-1:0];
        act_d.mode = shut_mode_e'({sr_q[LOAD_W], sr_q[LOAD_W+1]});
        act_en     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
      act_q <= SETTING_OFF;
    end else begin
      if (sr_en)  sr_q  <= sr_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (act_en) act_q <= act_d;
    end
  end

  assign active = act_q;

  AST_PARTIAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != $past(act_q)) |-> $past(stb_fall && cnt_q == CNT_FULL)); // R3

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_SAT); // R3

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    stb_fall |=> cnt_q == '0); // R3

endmodule

// File: rtl/shutcfg_out_sel.sv
module shutcfg_out_sel
  import shutcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmt_par,
  input  logic              shut_en,
  input  shut_setting_t     par_set,
  input  shut_setting_t     ser_set,
  output logic [LOAD_W-1:0] load_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              on_q
);

  shut_setting_t     pick;
  logic              illegal;
  logic              off;
  logic [LOAD_W-1:0] load_d;
  logic [MODE_W-1:0] mode_d;
  logic              on_d;

  assign pick    = fmt_par ? par_set : ser_set;
  assign illegal = &pick.load;
  assign off     = !shut_en || illegal || (pick.mode == MODE_NONE);

  always_comb begin
    if (off) begin
      load_d = '0;
      mode_d = MODE_NONE;
      on_d   = 1'b0;
    end else begin
      load_d = pick.load;
      mode_d = pick.mode;
      on_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      mode_q <= MODE_NONE;
      on_q   <= 1'b0;
    end else begin
      load_q <= load_d;
      mode_q <= mode_d;
      on_q   <= on_d;
    end
  end

  AST_EN_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !shut_en |=> (!on_q && mode_q == MODE_NONE && load_q == '0)); // R6

  AST_NO_ILLEGAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    on_q |-> load_q != '1); // R7

  AST_ON_HAS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    on_q |-> mode_q != MODE_NONE); // R8

  AST_OFF_IS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    !on_q |-> (load_q == '0 && mode_q == MODE_NONE)); // R8

endmodule

// File: rtl/shutcfg_top.sv
module shutcfg_top
  import shutcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmt_par,
  input  logic              std_625,
  input  logic [CODE_W-1:0] par_code,
  input  logic              ser_stb,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              shut_en,
  output logic [LOAD_W-1:0] load_val,
  output logic [MODE_W-1:0] shut_mode,
  output logic              shut_on
);

  shut_setting_t par_set;
  shut_setting_t ser_set;

  shutcfg_par_dec u_par (
    .code    (par_code),
    .std_625 (std_625),
    .setting (par_set)
  );

  shutcfg_ser_rx #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_stb (ser_stb),
    .ser_clk (ser_clk),
    .ser_dat (ser_dat),
    .active  (ser_set)
  );

  shutcfg_out_sel u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .fmt_par (fmt_par),
    .shut_en (shut_en),
    .par_set (par_set),
    .ser_set (ser_set),
    .load_q  (load_val),
    .mode_q  (shut_mode),
    .on_q    (shut_on)
  );

endmodule

// File: tb/sim_shutcfg_top.sv
module sim_shutcfg_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fmt_par = 1'b1;
  logic       std_625 = 1'b0;
  logic [2:0] par_code = 3'd0;
  logic       ser_stb = 1'b1;
  logic       ser_clk = 1'b0;
  logic       ser_dat = 1'b0;
  logic       shut_en = 1'b1;
  logic [8:0] load_val;
  logic [1:0] shut_mode;
  logic       shut_on;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [8:0] ser_l = 9'h000;
  logic [1:0] ser_m = 2'b11;

  always #4 clk = ~clk;

  shutcfg_top u0 (
    .clk (clk), .rst_n (rst_n), .fmt_par (fmt_par), .std_625 (std_625),
    .par_code (par_code), .ser_stb (ser_stb), .ser_clk (ser_clk),
    .ser_dat (ser_dat), .shut_en (shut_en), .load_val (load_val),
    .shut_mode (shut_mode), .shut_on (shut_on)
  );

  function automatic logic [10:0] par_table(input logic [2:0] c, input logic s);
    logic [8:0] l;
    logic [1:0] m;
    m = 2'b01;
    case (c)
      3'd0: l = s ? 9'h0C8 : 9'h0FA;
      3'd1: l = s ? 9'h0CA : 9'h0FC;
      3'd2: l = s ? 9'h0CE : 9'h100;
      3'd3: l = s ? 9'h0D6 : 9'h108;
      3'd4: l = s ? 9'h0E6 : 9'h118;
      3'd5: l = s ? 9'h105 : 9'h137;
      3'd6: begin l = s ? 9'h149 : 9'h196; m = 2'b00; end
      default: begin l = 9'h000; m = 2'b11; end
    endcase
    return {m, l};
  endfunction

  function automatic logic [11:0] expect_out();
    logic [8:0] l;
    logic [1:0] m;
    if (fmt_par) {m, l} = par_table(par_code, std_625);
    else begin l = ser_l; m = ser_m; end
    if (!shut_en || m == 2'b11 || l == 9'h1FF) return {1'b0, 2'b11, 9'h000};
    return {1'b1, m, l};
  endfunction

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req);
    logic [11:0] got, exp;
    got = {shut_on, shut_mode, load_val};
    exp = expect_out();
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got on=%0b mode=%b load=%h, expected on=%0b mode=%b load=%h",
               req, got[11], got[10:9], got[8:0], exp[11], exp[10:9], exp[8:0]);
    end
  endtask

  // Shifts nbits of frame {dummy, smd2, smd1, load} LSB first, then strobes.
  task automatic send_frame(input logic [8:0] l, input logic [1:0] m,
                            input int nbits, input logic dummy, input bit commit);
    logic [11:0] fr;
    fr = {dummy, m[0], m[1], l};
    ser_stb = 1'b1;
    wait_clks(4);
    for (int i = 0; i < nbits; i++) begin
      ser_dat = (i < 12) ? fr[i] : 1'b1;
      wait_clks(2);
      ser_clk = 1'b1;
      wait_clks(4);
      ser_clk = 1'b0;
      wait_clks(2);
    end
    ser_stb = 1'b0;
    wait_clks(4);
    ser_stb = 1'b1;
    wait_clks(4);
    if (commit) begin ser_l = l; ser_m = m; end
  endtask

  initial begin
    wait_clks(3);
    rst_n = 1'b1;
    wait_clks(1);
    // R9: reset state
    check("R9 reset outputs");
    fmt_par = 1'b0;
    wait_clks(3);
    check("R9 serial register after reset");

    // R4 / R5 / R1 / R8: full parallel sweep, both standards
    fmt_par = 1'b1;
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 8; c++) begin
        std_625  = s[0];
        par_code = c[2:0];
        wait_clks(3);
        check(s ? "R5 parallel 625 table" : "R4 parallel 525 table");
      end
    end

    // R2 / R8: serial frames over all active modes and several loads
    fmt_par = 1'b0;
    for (int m = 0; m < 3; m++) begin
      for (int k = 0; k < 3; k++) begin
        logic [8:0] l;
        l = (k == 0) ? 9'h0FA : (k == 1) ? 9'h155 : 9'h1FE;
        send_frame(l, m[1:0], 12, k[0], 1'b1);
        check("R2 serial frame mode/load");
      end
    end
    send_frame(9'h0AA, 2'b11, 12, 1'b0, 1'b1);
    check("R2 serial no-shutter mode");

    // R7: illegal load
    send_frame(9'h1FF, 2'b01, 12, 1'b0, 1'b1);
    check("R7 illegal load 1FF");

    // R3: short and long frames are dropped
    send_frame(9'h123, 2'b10, 12, 1'b1, 1'b1);
    check("R3 full frame before partial");
    send_frame(9'h0C3, 2'b01, 11, 1'b0, 1'b0);
    check("R3 11-bit frame ignored");
    send_frame(9'h0C3, 2'b01, 13, 1'b0, 1'b0);
    check("R3 13-bit frame ignored");

    // R10 / R1: commit while parallel shown, strobe fall coincident with select flip
    fmt_par  = 1'b1;
    par_code = 3'd3;
    std_625  = 1'b1;
    send_frame(9'h0E1, 2'b00, 12, 1'b0, 1'b1);
    check("R10 parallel shown during serial commit");
    fmt_par = 1'b0;
    wait_clks(3);
    check("R10 committed frame after switch");
    begin
      ser_stb = 1'b1;
      wait_clks(4);
      for (int i = 0; i < 12; i++) begin
        ser_dat = (i < 9) ? ~i[0] : (i == 9);
        wait_clks(2); ser_clk = 1'b1; wait_clks(4); ser_clk = 1'b0; wait_clks(2);
      end
      ser_stb = 1'b0;
      fmt_par = 1'b1;
      wait_clks(1);
      check("R1 parallel at coincident switch");
      wait_clks(7);
      ser_stb = 1'b1;
      ser_l = 9'h155;
      ser_m = 2'b10;
      fmt_par = 1'b0;
      wait_clks(3);
      check("R10 coincident commit visible");
    end

    // R6: enable low masks both sources, commit while disabled
    shut_en = 1'b0;
    wait_clks(3);
    check("R6 serial masked");
    fmt_par = 1'b1;
    wait_clks(3);
    check("R6 parallel masked");
    fmt_par = 1'b0;
    send_frame(9'h101, 2'b01, 12, 1'b1, 1'b1);
    check("R6 masked after commit");
    shut_en = 1'b1;
    wait_clks(3);
    check("R6 enable restored shows commit");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hang, expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule